// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

A clocked single-port memory with a 36-bit word split into four 9-bit byte lanes, driven through a cache-style control interface. Two address strobes can open an access. One strobe belongs to the processor side and one to the cache controller side. After an access opens, a two-bit beat counter steps the low address bits through a linear burst. An advance input can also stall the counter. Each beat can be a full-word write, a byte-lane write or a read. Read data is registered and comes out one clock after its beat.

The model produces the output-drive decision as an enable pin, `rd_drive`, and does not use a bidirectional bus. The surrounding pad logic turns `rd_data` and `rd_drive` into the tri-state data pins. A sleep input stops all activity. For a fixed window after sleep is released, any strobe is refused and reported on `proto_err`. The memory is not cleared by reset. The default depth is 1K words. Setting `ADDR_W` to 17 gives the full 128K-word organisation.

There is no valid/ready handshake. The interface follows a fixed cycle timing: an access opened in one cycle returns its data in the next cycle, and there is no back-pressure.

Top module: `burst_sram`

## Requirements
- R1: Write lanes are chosen as follows. With `gw_n` low, all four lanes are written. With `gw_n` high and `bwe_n` low, a lane is written only if its bit in `lane_n` is low. Lane i covers data bits [9i+8:9i]. With both `gw_n` and `bwe_n` high, the beat is a read.
- R2: When an access opens, the beat counter loads `addr[1:0]` and the upper bits are held as the burst base. On each later beat with `adv_n` low, the counter advances by one modulo 4, so a start at low bits 3 visits 3,0,1,2. The base does not change.
- R3: On a continuing beat with `adv_n` high, the counter holds and the beat accesses the same address again.
- R4: A low `stb_cpu_n` while `sel_a_n` is high is ignored. The cycle behaves exactly as if that strobe were high, so a running burst continues.
- R5: `stb_ctl_n` opens an access whatever the level of `sel_a_n`. If any of `sel_a_n` low, `sel_b` high, `sel_c_n` low is not met when either strobe opens an access, the device is deselected. In that case no data returns and no later beats occur until a new start.
- R6: A read beat places the word on `rd_data` in the following cycle. `rd_drive` is high only in a cycle that follows a read beat, while `oe_n` is low, and while the current cycle is not a write beat.
- R7: During a write beat, `rd_drive` is low whatever `oe_n` is.
- R8: While `sleep` is high, no beat is performed, any burst is ended, and `rd_drive` stays low in the cycle after.
- R9: For the two cycles after `sleep` falls, both strobes are refused. A strobe that arrives in that window raises `proto_err` for one cycle, in the cycle after it.
- R10: After reset, no burst is open, `rd_drive` is low and `proto_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address sampled when an access opens |
| stb_cpu_n | input | 1 | Processor-side address strobe, active low, masked by `sel_a_n` |
| stb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high stalls the counter |
| sel_a_n | input | 1 | Primary select, active low |
| sel_b | input | 1 | Second select, active high |
| sel_c_n | input | 1 | Third select, active low |
| oe_n | input | 1 | Output enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| sleep | input | 1 | Sleep request, active high |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_drive | output | 1 | High when the data pins should be driven |
| proto_err | output | 1 | Strobe seen inside the sleep-recovery window |

## Verification
Two things can meet in one cycle: the data returning from a read beat and a write beat that is just starting. That cycle is where the output enable must yield to the write. The random phase creates it by mixing reads and writes inside running bursts with `oe_n` mostly low. A directed burst also reads and then immediately writes. The bench checks `rd_drive` in each such cycle against a reference that blocks the drive whenever the current beat writes. It also checks the word returned by the preceding read against a shadow memory.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_START,
    CYC_DESEL,
    CYC_CONT,
    CYC_BLOCK
  } cyc_e;
endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sleep,
  input  logic             rec_busy,
  input  logic             active_q,
  input  logic             stb_cpu_n,
  input  logic             stb_ctl_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_n,
  output cyc_e             kind,
  output logic             start_sel,
  output logic             desel,
  output logic             cont,
  output logic             acc,
  output logic [LANES-1:0] lane_we,
  output logic             is_write,
  output logic             rec_err
);
  logic cpu_go, ctl_go, all_sel, blocked;

  assign cpu_go  = ~stb_cpu_n & ~sel_a_n;
  assign ctl_go  = ~stb_ctl_n;
  assign all_sel = ~sel_a_n & sel_b & ~sel_c_n;
  assign blocked = sleep | rec_busy;

  always_comb begin
    if (blocked)                kind = CYC_BLOCK;
    else if (cpu_go || ctl_go)  kind = all_sel ? CYC_START : CYC_DESEL;
    else if (active_q)          kind = CYC_CONT;
    else                        kind = CYC_IDLE;
  end

  assign start_sel = (kind == CYC_START);
  assign desel     = (kind == CYC_DESEL);
  assign cont      = (kind == CYC_CONT);
  assign acc       = start_sel | cont;

  always_comb begin
    if (!gw_n)       lane_we = {LANES{1'b1}};
    else if (!bwe_n) lane_we = ~lane_n;
    else             lane_we = '0;
    if (!acc)        lane_we = '0;
  end

  assign is_write = |lane_we;
  assign rec_err  = ~sleep & rec_busy & (~stb_cpu_n | ~stb_ctl_n);
endmodule

// File: rtl/burst_sram_ctr.sv
module burst_sram_ctr
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              start_sel,
  input  logic              cont,
  input  logic              adv_n,
  input  logic              stop,
  output logic              step,
  output logic              active_q,
  output logic [BEAT_W-1:0] cnt_q,
  output logic [ADDR_W-BEAT_W-1:0] base_q,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [BEAT_W-1:0] cnt_nx;

  assign step   = cont & ~adv_n;
  assign cnt_nx = step ? cnt_q + 1'b1 : cnt_q;

  always_comb begin
    if (start_sel) cur_addr = addr;
    else           cur_addr = {base_q, cnt_nx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
    end else if (stop) begin
      active_q <= 1'b0;
    end else if (start_sel) begin
      active_q <= 1'b1;
      cnt_q    <= addr[BEAT_W-1:0];
      base_q   <= addr[ADDR_W-1:BEAT_W];
    end else if (step) begin
      cnt_q    <= cnt_nx;
    end
  end
endmodule

// File: rtl/burst_sram_mem.sv
module burst_sram_mem #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       a,
  input  logic [LANES-1:0]        we,
  input  logic                    rd_en,
  input  logic [LANES*LANE_W-1:0] wd,
  output logic [LANES*LANE_W-1:0] rd_q,
  output logic                    rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) store[a] <= wd[g*LANE_W +: LANE_W];
      if (rd_en) rd_q[g*LANE_W +: LANE_W] <= store[a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int REC_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    stb_cpu_n,
  input  logic                    stb_ctl_n,
  input  logic                    adv_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    oe_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive,
  output logic                    proto_err
);
  localparam int REC_W = $clog2(REC_CYC + 1);

  cyc_e                     kind;
  logic                     start_sel, desel, cont, acc, is_write, rec_err;
  logic                     step, active_q, rec_busy, rd_en, rd_valid;
  logic [LANES-1:0]         lane_we;
  logic [BEAT_W-1:0]        cnt_q;
  logic [ADDR_W-BEAT_W-1:0] base_q;
  logic [ADDR_W-1:0]        cur_addr;
  logic [REC_W-1:0]         rec_cnt;

  assign rec_busy = (rec_cnt != '0);
  assign rd_en    = acc & ~is_write;

  burst_sram_decode #(.LANES(LANES)) u_dec (
    .sleep(sleep), .rec_busy(rec_busy), .active_q(active_q),
    .stb_cpu_n(stb_cpu_n), .stb_ctl_n(stb_ctl_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .lane_n(lane_n),
    .kind(kind), .start_sel(start_sel), .desel(desel), .cont(cont),
    .acc(acc), .lane_we(lane_we), .is_write(is_write), .rec_err(rec_err)
  );

  burst_sram_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .start_sel(start_sel), .cont(cont), .adv_n(adv_n),
    .stop(sleep | desel), .step(step), .active_q(active_q),
    .cnt_q(cnt_q), .base_q(base_q), .cur_addr(cur_addr)
  );

  burst_sram_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .a(cur_addr), .we(lane_we), .rd_en(rd_en),
    .wd(wr_data), .rd_q(rd_data), .rd_valid(rd_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_cnt   <= '0;
      proto_err <= 1'b0;
    end else begin
      if (sleep)         rec_cnt <= REC_W'(REC_CYC);
      else if (rec_busy) rec_cnt <= rec_cnt - 1'b1;
      proto_err <= rec_err;
    end
  end

  assign rd_drive = rd_valid & ~oe_n & ~is_write;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int BASE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              gw_n,
  input logic              adv_n,
  input logic              step,
  input logic              cont,
  input logic              acc,
  input logic              rd_en,
  input logic              rec_busy,
  input logic              active_q,
  input logic [1:0]        cnt_q,
  input logic [BASE_W-1:0] base_q,
  input logic              rd_drive,
  input logic              proto_err
);
  assert_cnt_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == $past(cnt_q) + 2'd1);

  assert_base_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> $stable(base_q));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && adv_n) |=> $stable(cnt_q));

  assert_drive_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> $past(rd_en));

  assert_quiet_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && acc) |-> !rd_drive);

  assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> (!rd_drive && !active_q));

  assert_rec_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(!sleep && rec_busy));
endmodule

bind burst_sram burst_sram_chk #(.BASE_W(ADDR_W - 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .gw_n(gw_n), .adv_n(adv_n),
  .step(step), .cont(cont), .acc(acc), .rd_en(rd_en), .rec_busy(rec_busy),
  .active_q(active_q), .cnt_q(cnt_q), .base_q(base_q),
  .rd_drive(rd_drive), .proto_err(proto_err)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DW     = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic stb_cpu_n = 1'b1, stb_ctl_n = 1'b1, adv_n = 1'b1;
  logic sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0, oe_n = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1, sleep = 1'b0;
  logic [3:0] lane_n = 4'hF;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_drive, proto_err;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(ADDR_W)) i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .stb_cpu_n(stb_cpu_n),
    .stb_ctl_n(stb_ctl_n), .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .oe_n(oe_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .lane_n(lane_n), .sleep(sleep), .wr_data(wr_data), .rd_data(rd_data),
    .rd_drive(rd_drive), .proto_err(proto_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string tag = "R6";

  // reference state
  bit m_active = 0, m_rd = 0, m_err = 0;
  int m_base = 0, m_cnt = 0, m_rec = 0;
  logic [DW-1:0] m_rdata = '0;
  logic [DW-1:0] m_mem [DEPTH];

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [3:0] we);
    logic [DW-1:0] r = old;
    for (int i = 0; i < 4; i++) if (we[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [3:0] lanes_of(logic g, logic b, logic [3:0] ln);
    if (!g) return 4'hF;
    if (!b) return ~ln;
    return 4'h0;
  endfunction

  // One clock: inputs already set just after a falling edge.
  task automatic tick();
    bit blocked, cpu_go, ctl_go, allsel, start, cont, acc, wr, n_err;
    int a, c, n_rec;
    logic [3:0] we;
    #1;
    blocked = sleep || (m_rec != 0);
    cpu_go  = !stb_cpu_n && !sel_a_n;
    ctl_go  = !stb_ctl_n;
    allsel  = !sel_a_n && sel_b && !sel_c_n;
    start   = !blocked && (cpu_go || ctl_go);
    cont    = !blocked && !(cpu_go || ctl_go) && m_active;
    acc     = (start && allsel) || cont;
    c = adv_n ? m_cnt : (m_cnt + 1) % 4;
    a = (start && allsel) ? int'(addr) : m_base * 4 + c;
    we = acc ? lanes_of(gw_n, bwe_n, lane_n) : 4'h0;
    wr = (we != 0);
    check(wr ? "R7" : "R6", DW'(rd_drive), DW'(m_rd && !oe_n && !wr));
    n_err = !sleep && (m_rec != 0) && (!stb_cpu_n || !stb_ctl_n);
    n_rec = sleep ? 2 : (m_rec != 0 ? m_rec - 1 : 0);
    if (acc && !wr) m_rdata = m_mem[a];
    m_rd = acc && !wr;
    if (wr) m_mem[a] = merge(m_mem[a], wr_data, we);
    if (sleep) m_active = 0;
    else if (start && !allsel) m_active = 0;
    else if (start) begin
      m_active = 1; m_base = int'(addr) / 4; m_cnt = int'(addr) % 4;
    end else if (cont) m_cnt = c;
    m_rec = n_rec;
    m_err = n_err;
    @(posedge clk); #1;
    check("R9", DW'(proto_err), DW'(m_err));
    if (m_rd) check(tag, rd_data, m_rdata);
    @(negedge clk);
  endtask

  task automatic idle_in();
    stb_cpu_n = 1; stb_ctl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1;
    lane_n = 4'hF; sleep = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0; oe_n = 0;
  endtask

  task automatic start_ctl(int a, bit write, logic [DW-1:0] d);
    idle_in(); stb_ctl_n = 0; addr = ADDR_W'(a); gw_n = !write; wr_data = d;
    tick();
  endtask

  task automatic beat(bit adv, bit write, logic [DW-1:0] d);
    idle_in(); adv_n = !adv; gw_n = !write; wr_data = d;
    tick();
  endtask

  initial begin
    logic [31:0] t;
    void'($urandom(32'd4242));
    idle_in();
    repeat (3) @(negedge clk);
    tag = "R10";
    check("R10", DW'(rd_drive), 0);
    check("R10", DW'(proto_err), 0);
    rst_n = 1;
    @(negedge clk);
    beat(1, 0, '0);          // no burst open: no data must return
    check("R10", DW'(rd_drive), 0);

    // fill memory with bursts of writes (R1 global write, R2 stepping)
    tag = "R2";
    for (int a = 0; a < DEPTH; a += 4) begin
      t = $urandom;
      start_ctl(a, 1, {t[3:0], $urandom()});
      for (int k = 1; k < 4; k++) begin
        t = $urandom;
        beat(1, 1, {t[3:0], $urandom()});
      end
    end

    // R2: wrap from low bits 3
    tag = "R2";
    start_ctl(8'h47 | 3, 0, '0);
    for (int k = 0; k < 4; k++) beat(1, 0, '0);

    // R3: suspended burst repeats the address
    tag = "R3";
    start_ctl(20, 0, '0);
    beat(0, 0, '0);
    beat(0, 0, '0);
    beat(1, 0, '0);

    // R1: byte-lane write then read back
    tag = "R1";
    start_ctl(100, 0, '0);
    idle_in(); adv_n = 1; bwe_n = 0; lane_n = 4'b1010; wr_data = 36'h1_2345_6789;
    tick();
    idle_in(); adv_n = 1; bwe_n = 1; lane_n = 4'b0000; tick(); // no write: read
    start_ctl(101, 0, '0);

    // R7: read immediately followed by write in one burst
    tag = "R7";
    start_ctl(200, 0, '0);
    beat(1, 1, 36'hA_BCDE_F012);
    oe_n = 1; beat(1, 0, '0);

    // R4: processor strobe masked by primary select, burst continues
    tag = "R4";
    start_ctl(300, 0, '0);
    idle_in(); stb_cpu_n = 0; sel_a_n = 1; adv_n = 0; addr = 10'd500; tick();
    beat(1, 0, '0);
    idle_in(); stb_cpu_n = 0; addr = 10'd600; tick();  // accepted start

    // R5: controller strobe with a select off deselects
    tag = "R5";
    start_ctl(400, 0, '0);
    idle_in(); stb_ctl_n = 0; sel_b = 0; addr = 10'd410; tick();
    beat(1, 0, '0);
    check("R5", DW'(rd_drive), 0);
    idle_in(); stb_ctl_n = 0; sel_a_n = 1; addr = 10'd420; tick(); // desel via ctl
    idle_in(); stb_ctl_n = 0; addr = 10'd430; tick();

    // R8 / R9: sleep, recovery window with strobes
    tag = "R8";
    idle_in(); stb_ctl_n = 0; sel_c_n = 1; tick();
    idle_in(); sleep = 1; tick();
    idle_in(); sleep = 1; stb_ctl_n = 0; addr = 10'd7; tick();
    check("R8", DW'(rd_drive), 0);
    tag = "R9";
    idle_in(); stb_ctl_n = 0; addr = 10'd9; tick();
    check("R9", DW'(proto_err), 1);
    idle_in(); stb_cpu_n = 0; addr = 10'd11; tick();
    check("R9", DW'(proto_err), 1);
    idle_in(); stb_ctl_n = 0; addr = 10'd13; tick();
    check("R9", DW'(proto_err), 0);

    // constrained random
    tag = "R6";
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom % 16;
      stb_cpu_n = !(r == 0);
      stb_ctl_n = !(r == 1 || r == 2);
      sel_a_n = ($urandom % 8 == 0);
      sel_b   = ($urandom % 8 != 0);
      sel_c_n = ($urandom % 8 == 0);
      adv_n   = ($urandom % 3 == 0);
      gw_n    = ($urandom % 4 != 0);
      bwe_n   = ($urandom % 3 != 0);
      lane_n  = 4'($urandom);
      oe_n    = ($urandom % 5 == 0);
      sleep   = ($urandom % 150 == 0);
      addr    = ADDR_W'($urandom);
      t = $urandom;
      wr_data = {t[3:0], $urandom()};
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule